// File: doc/BRIEF.md
# Dynamic Capacity Configuration Responder

This block answers the "read dynamic capacity configuration" query of a memory expander's command mailbox. It holds a small table of region descriptors. Each descriptor has a base address, a decode length counted in 256 MB units, a region length, a block size, a 32-bit handle and a flags byte. The table is loaded through a simple write port. The same port sets how many regions are configured.

A request brings a command-set and command code, an input payload length, a requested record count and a start index. The block accepts the request in one cycle and raises a status pulse with a code and a payload length on the next edge. For a good request it then streams the reply payload one byte per cycle over a valid/ready handshake. The payload is an 8-byte header followed by one 40-byte record for each returned region. All multi-byte fields are little-endian.

Top module: `dcConfigResponder`

## Requirements
- R1: A request is supported only when the command-set code is 0x48, the command code is 0x00 and at least one region is configured. Otherwise the status code is 1 (unsupported), the length is 0 and no payload follows.
- R2: A supported request whose input length is not exactly 2 gets status code 3 (bad length), length 0 and no payload.
- R3: A supported, well-sized request whose start index is greater than or equal to the configured region count gets status code 2 (bad input), length 0 and no payload.
- R4: A valid request returns N records, where N is the smaller of the requested count and (configured count minus start index). The status code is 0 and the reported length is 8 + 40*N.
- R5: Header byte 0 carries N and header bytes 1 to 7 are zero.
- R6: Each record covers region start+k, for k counting up from 0. Its byte offsets are: base at 0-7, decode length at 8-15, region length at 16-23, block size at 24-31, handle at 32-35, flags at 36, and zero at 37-39. Every field is least-significant byte first.
- R7: A requested count of 0 with a valid start index succeeds with only the 8-byte header and N = 0.
- R8: A payload byte and its last marker stay unchanged while valid is high and ready is low. The last marker is high only on the final byte, and the block returns to idle after that byte is accepted.
- R9: Table writes are ignored while a command is being accepted or answered. A region-count write larger than the table size is also ignored.
- R10: After reset, command ready is high, payload valid and status valid are low, and the configured region count is 0.
- R11: Status valid is high in the cycle after a request is accepted. Command ready stays low from that point until the final payload byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblWrEn | input | 1 | Table write strobe |
| tblWrSel | input | 3 | Field select: 0 base, 1 decode length, 2 region length, 3 block size, 4 handle, 5 flags, 6 region count |
| tblWrIdx | input | 8 | Region index for the write |
| tblWrData | input | 64 | Write data, right-aligned |
| cmdValid | input | 1 | Request present |
| cmdReady | output | 1 | Block idle and able to take a request |
| cmdSet | input | 8 | Command-set code |
| cmdOp | input | 8 | Command code within the set |
| cmdLen | input | 16 | Input payload length in bytes |
| reqCount | input | 8 | Requested record count (request byte 0) |
| reqStart | input | 8 | Start region index (request byte 1) |
| rspValid | output | 1 | Payload byte present |
| rspReady | input | 1 | Consumer takes the payload byte |
| rspData | output | 8 | Payload byte |
| rspLast | output | 1 | Final payload byte |
| stsValid | output | 1 | Status pulse |
| stsCode | output | 2 | 0 ok, 1 unsupported, 2 bad input, 3 bad length |
| stsLen | output | 16 | Reply payload length in bytes |

## Verification
The hardest case to reach is a table write that lands while a reply is still streaming. The payload has to be held back for that write to be seen as ignored. The bench stalls the consumer after accepting a request and writes both a region field and the region count during the stall. It then drains the reply and runs a second query that reads the untouched values back. Clamped reads that run off the end of the table, and stalls on record bytes, show the counters walking across record boundaries.

// File: rtl/dcCfgPkg.sv
package dcCfgPkg;
  localparam int HDR_BYTES = 8;
  localparam int REC_BYTES = 40;
  localparam logic [7:0] CMD_SET = 8'h48;
  localparam logic [7:0] CMD_OP = 8'h00;
  localparam logic [15:0] REQ_LEN = 16'd2;

  typedef enum logic [1:0] {
    ST_OK = 2'd0,
    ST_UNSUP = 2'd1,
    ST_BADIN = 2'd2,
    ST_BADLEN = 2'd3
  } stsCode_e;

  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_DLEN = 3'd1,
    SEL_RLEN = 3'd2,
    SEL_BSIZE = 3'd3,
    SEL_HANDLE = 3'd4,
    SEL_FLAGS = 3'd5,
    SEL_COUNT = 3'd6
  } tblSel_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic [7:0] recCount;
    logic [7:0] startIdx;
  } dpStrobe_t;
endpackage

// File: rtl/dcCfgCtrl.sv
module dcCfgCtrl
  import dcCfgPkg::*;
#(
  parameter int MAX_REGIONS = 8,
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdValid,
  output logic cmdReady,
  input  logic [7:0] cmdSet,
  input  logic [7:0] cmdOp,
  input  logic [15:0] cmdLen,
  input  logic [7:0] reqCount,
  input  logic [7:0] reqStart,
  input  logic [CNT_W-1:0] regionCount,
  output logic busy,
  output logic rspValid,
  input  logic rspReady,
  output logic rspLast,
  output logic stsValid,
  output logic [1:0] stsCode,
  output logic [15:0] stsLen,
  output dpStrobe_t strobe
);
  typedef enum logic {S_IDLE, S_SEND} state_e;
  localparam logic [15:0] MAX_LEN = 16'(HDR_BYTES + REC_BYTES * MAX_REGIONS);

  state_e state;
  logic [15:0] remain;
  logic accept;
  logic [7:0] countExt, avail, recN;
  logic [15:0] payLen;
  stsCode_e decision;

  assign accept = cmdValid && cmdReady;
  assign countExt = {{(8 - CNT_W){1'b0}}, regionCount};
  assign avail = countExt - reqStart;
  assign recN = (reqCount < avail) ? reqCount : avail;
  assign payLen = 16'(HDR_BYTES) + 16'(REC_BYTES) * {8'd0, recN};

  always_comb begin
    if (cmdSet != CMD_SET || cmdOp != CMD_OP || countExt == 8'd0) decision = ST_UNSUP;
    else if (cmdLen != REQ_LEN) decision = ST_BADLEN;
    else if (reqStart >= countExt) decision = ST_BADIN;
    else decision = ST_OK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      remain <= '0;
      stsValid <= 1'b0;
      stsCode <= '0;
      stsLen <= '0;
    end else begin
      stsValid <= accept;
      if (accept) begin
        stsCode <= decision;
        stsLen <= (decision == ST_OK) ? payLen : 16'd0;
        if (decision == ST_OK) begin
          state <= S_SEND;
          remain <= payLen;
        end
      end else if (state == S_SEND && rspReady) begin
        remain <= remain - 16'd1;
        if (remain == 16'd1) state <= S_IDLE;
      end
    end
  end

  assign cmdReady = (state == S_IDLE);
  assign busy = (state != S_IDLE);
  assign rspValid = (state == S_SEND);
  assign rspLast = rspValid && (remain == 16'd1);

  always_comb begin
    strobe.load = accept && (decision == ST_OK);
    strobe.advance = rspValid && rspReady;
    strobe.recCount = recN;
    strobe.startIdx = reqStart;
  end

  assert_last_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspLast));
  assert_last_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspLast && rspReady |=> cmdReady && !rspValid);
  assert_err_no_payload_R3: assert property (@(posedge clk) disable iff (!rstN)
    stsValid && stsCode != ST_OK |-> !rspValid && stsLen == 16'd0);
  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    stsValid && stsCode == ST_OK |-> stsLen >= 16'(HDR_BYTES) && stsLen <= MAX_LEN);
  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !cmdReady);
endmodule

// File: rtl/dcCfgData.sv
module dcCfgData
  import dcCfgPkg::*;
#(
  parameter int MAX_REGIONS = 8,
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic tblWrEn,
  input  logic [2:0] tblWrSel,
  input  logic [7:0] tblWrIdx,
  input  logic [63:0] tblWrData,
  input  logic lockTable,
  input  dpStrobe_t strobe,
  output logic [CNT_W-1:0] regionCount,
  output logic [7:0] rspData
);
  logic [63:0] baseMem [MAX_REGIONS];
  logic [63:0] dlenMem [MAX_REGIONS];
  logic [63:0] rlenMem [MAX_REGIONS];
  logic [63:0] bsizeMem [MAX_REGIONS];
  logic [31:0] handleMem [MAX_REGIONS];
  logic [7:0] flagsMem [MAX_REGIONS];

  logic wrOk, idxOk;
  logic [IDX_W-1:0] wrIdx;
  logic inHdr;
  logic [2:0] hdrIdx;
  logic [IDX_W-1:0] recIdx;
  logic [5:0] recByte;
  logic [7:0] recCountR;
  logic [63:0] word;

  assign wrOk = tblWrEn && !lockTable;
  assign idxOk = tblWrIdx < 8'(MAX_REGIONS);
  assign wrIdx = tblWrIdx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionCount <= '0;
      for (int i = 0; i < MAX_REGIONS; i++) begin
        baseMem[i] <= '0;
        dlenMem[i] <= '0;
        rlenMem[i] <= '0;
        bsizeMem[i] <= '0;
        handleMem[i] <= '0;
        flagsMem[i] <= '0;
      end
    end else if (wrOk) begin
      if (tblWrSel == SEL_COUNT) begin
        if (tblWrData <= 64'(MAX_REGIONS)) regionCount <= tblWrData[CNT_W-1:0];
      end else if (idxOk) begin
        case (tblWrSel)
          SEL_BASE: baseMem[wrIdx] <= tblWrData;
          SEL_DLEN: dlenMem[wrIdx] <= tblWrData;
          SEL_RLEN: rlenMem[wrIdx] <= tblWrData;
          SEL_BSIZE: bsizeMem[wrIdx] <= tblWrData;
          SEL_HANDLE: handleMem[wrIdx] <= tblWrData[31:0];
          SEL_FLAGS: flagsMem[wrIdx] <= tblWrData[7:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inHdr <= 1'b1;
      hdrIdx <= '0;
      recIdx <= '0;
      recByte <= '0;
      recCountR <= '0;
    end else if (strobe.load) begin
      inHdr <= 1'b1;
      hdrIdx <= '0;
      recIdx <= strobe.startIdx[IDX_W-1:0];
      recByte <= '0;
      recCountR <= strobe.recCount;
    end else if (strobe.advance) begin
      if (inHdr) begin
        if (hdrIdx == 3'd7) inHdr <= 1'b0;
        else hdrIdx <= hdrIdx + 3'd1;
      end else if (recByte == 6'(REC_BYTES - 1)) begin
        recByte <= '0;
        recIdx <= recIdx + 1'b1;
      end else begin
        recByte <= recByte + 6'd1;
      end
    end
  end

  always_comb begin
    case (recByte[5:3])
      3'd0: word = baseMem[recIdx];
      3'd1: word = dlenMem[recIdx];
      3'd2: word = rlenMem[recIdx];
      3'd3: word = bsizeMem[recIdx];
      3'd4: word = {24'd0, flagsMem[recIdx], handleMem[recIdx]};
      default: word = '0;
    endcase
    if (inHdr) rspData = (hdrIdx == 3'd0) ? recCountR : 8'd0;
    else rspData = word[{recByte[2:0], 3'b000} +: 8];
  end

  assert_locked_table_R9: assert property (@(posedge clk) disable iff (!rstN)
    lockTable && tblWrEn |=> $stable(regionCount));
  assert_rec_byte_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    recByte < 6'(REC_BYTES));
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    regionCount <= CNT_W'(MAX_REGIONS));
endmodule

// File: rtl/dcConfigResponder.sv
module dcConfigResponder
  import dcCfgPkg::*;
#(
  parameter int MAX_REGIONS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic tblWrEn,
  input  logic [2:0] tblWrSel,
  input  logic [7:0] tblWrIdx,
  input  logic [63:0] tblWrData,
  input  logic cmdValid,
  output logic cmdReady,
  input  logic [7:0] cmdSet,
  input  logic [7:0] cmdOp,
  input  logic [15:0] cmdLen,
  input  logic [7:0] reqCount,
  input  logic [7:0] reqStart,
  output logic rspValid,
  input  logic rspReady,
  output logic [7:0] rspData,
  output logic rspLast,
  output logic stsValid,
  output logic [1:0] stsCode,
  output logic [15:0] stsLen
);
  localparam int CNT_W = $clog2(MAX_REGIONS + 1);
  localparam int IDX_W = (MAX_REGIONS > 1) ? $clog2(MAX_REGIONS) : 1;

  dpStrobe_t strobe;
  logic [CNT_W-1:0] regionCount;
  logic busy;
  logic lockTable;

  assign lockTable = busy || (cmdValid && cmdReady);

  dcCfgCtrl #(.MAX_REGIONS(MAX_REGIONS), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdSet(cmdSet), .cmdOp(cmdOp), .cmdLen(cmdLen), .reqCount(reqCount),
    .reqStart(reqStart), .regionCount(regionCount), .busy(busy),
    .rspValid(rspValid), .rspReady(rspReady), .rspLast(rspLast),
    .stsValid(stsValid), .stsCode(stsCode), .stsLen(stsLen), .strobe(strobe)
  );

  dcCfgData #(.MAX_REGIONS(MAX_REGIONS), .CNT_W(CNT_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrSel(tblWrSel),
    .tblWrIdx(tblWrIdx), .tblWrData(tblWrData), .lockTable(lockTable),
    .strobe(strobe), .regionCount(regionCount), .rspData(rspData)
  );

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspData));
endmodule

// File: tb/tb_dcConfigResponder.sv
module tb_dcConfigResponder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tblWrEn = 1'b0;
  logic [2:0] tblWrSel = '0;
  logic [7:0] tblWrIdx = '0;
  logic [63:0] tblWrData = '0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [7:0] cmdSet = '0, cmdOp = '0, reqCount = '0, reqStart = '0;
  logic [15:0] cmdLen = '0;
  logic rspValid, rspLast, stsValid;
  logic rspReady = 1'b0;
  logic [7:0] rspData;
  logic [1:0] stsCode;
  logic [15:0] stsLen;

  int total = 0;
  int failed = 0;
  int cyc = 0;

  logic [63:0] mFld [8][4];
  logic [31:0] mHnd [8];
  logic [7:0] mFlg [8];
  int mCount = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dcConfigResponder dut (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrSel(tblWrSel),
    .tblWrIdx(tblWrIdx), .tblWrData(tblWrData), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdSet(cmdSet), .cmdOp(cmdOp), .cmdLen(cmdLen),
    .reqCount(reqCount), .reqStart(reqStart), .rspValid(rspValid),
    .rspReady(rspReady), .rspData(rspData), .rspLast(rspLast),
    .stsValid(stsValid), .stsCode(stsCode), .stsLen(stsLen)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int start, input int n, input int idx);
    int off, r, b;
    if (idx < 8) return (idx == 0) ? 8'(n) : 8'd0;
    off = idx - 8;
    r = start + off / 40;
    b = off % 40;
    if (b < 32) return 8'(mFld[r][b / 8] >> ((b % 8) * 8));
    if (b < 36) return 8'(mHnd[r] >> ((b - 32) * 8));
    if (b == 36) return mFlg[r];
    return 8'd0;
  endfunction

  task automatic writeTbl(input logic [2:0] sel, input int idx, input logic [63:0] data);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrSel = sel; tblWrIdx = 8'(idx); tblWrData = data;
    @(posedge clk); #1;
    tblWrEn = 1'b0;
  endtask

  task automatic loadRegion(input int r);
    for (int f = 0; f < 4; f++) begin
      mFld[r][f] = 64'h0011223344556677 + 64'(r) * 64'h0101010101010101
                   + 64'(f) * 64'h1000000000000000;
      writeTbl(3'(f), r, mFld[r][f]);
    end
    mHnd[r] = 32'hA0B0C0D0 + 32'(r);
    writeTbl(3'd4, r, {32'hFFFF_FFFF, mHnd[r]});
    mFlg[r] = 8'h80 | 8'(r);
    writeTbl(3'd5, r, 64'(mFlg[r]));
  endtask

  // runs one request; stall inserts consumer back-pressure, busyWr writes the table mid-reply
  task automatic runQuery(input logic [7:0] set, input logic [7:0] op, input logic [15:0] len,
                          input int cnt, input int start, input bit stall, input bit busyWr,
                          input string req);
    int expCode, expN, expLen, gotN;
    logic [7:0] held;
    bit pendHold;
    if (mCount == 0 || set != 8'h48 || op != 8'h00) expCode = 1;
    else if (len != 16'd2) expCode = 3;
    else if (start >= mCount) expCode = 2;
    else expCode = 0;
    expN = (expCode == 0) ? ((cnt < mCount - start) ? cnt : mCount - start) : 0;
    expLen = (expCode == 0) ? 8 + 40 * expN : 0;
    @(negedge clk);
    rspReady = 1'b0;
    cmdValid = 1'b1; cmdSet = set; cmdOp = op; cmdLen = len;
    reqCount = 8'(cnt); reqStart = 8'(start);
    @(posedge clk); #1;
    cmdValid = 1'b0;
    chk(stsValid == 1'b1, "R11", {req, " status pulse"}, stsValid, 1);
    chk(stsCode == 2'(expCode), req, "status code", stsCode, expCode);
    chk(stsLen == 16'(expLen), req, "status length", stsLen, expLen);
    @(posedge clk); #1;
    chk(stsValid == 1'b0, "R11", "status pulse ends", stsValid, 0);
    chk(cmdReady == (expCode != 0), "R11", "ready while replying", cmdReady, expCode != 0);
    if (expCode != 0) chk(rspValid == 1'b0, req, "no payload on error", rspValid, 0);
    if (busyWr) begin
      writeTbl(3'd0, 0, 64'hDEAD_BEEF_0000_0001);
      writeTbl(3'd6, 0, 64'd2);
    end
    gotN = 0;
    pendHold = 1'b0;
    held = '0;
    while (gotN < 400) begin
      @(negedge clk);
      if (!rspValid) break;
      if (pendHold) chk(rspData == held, "R8", "byte held under stall", rspData, held);
      rspReady = !(stall && (cyc % 3 == 1));
      pendHold = !rspReady;
      held = rspData;
      if (rspReady) begin
        chk(rspData == expByte(start, expN, gotN), (gotN < 8) ? "R5" : "R6",
            $sformatf("%s byte %0d", req, gotN), rspData, expByte(start, expN, gotN));
        chk(rspLast == (gotN == expLen - 1), "R8", "last marker", rspLast, gotN == expLen - 1);
        gotN++;
      end
    end
    rspReady = 1'b0;
    chk(gotN == expLen, req, "payload byte count", gotN, expLen);
    chk(cmdReady == 1'b1, "R8", "idle after reply", cmdReady, 1);
  endtask

  task automatic testReset();
    #1;
    chk(cmdReady == 1'b1, "R10", "cmdReady after reset", cmdReady, 1);
    chk(rspValid == 1'b0, "R10", "rspValid after reset", rspValid, 0);
    chk(stsValid == 1'b0, "R10", "stsValid after reset", stsValid, 0);
    runQuery(8'h48, 8'h00, 16'd2, 1, 0, 1'b0, 1'b0, "R10");
  endtask

  task automatic testDecode();
    runQuery(8'h47, 8'h00, 16'd2, 1, 0, 1'b0, 1'b0, "R1");
    runQuery(8'h48, 8'h01, 16'd2, 1, 0, 1'b0, 1'b0, "R1");
    runQuery(8'h48, 8'h00, 16'd3, 1, 0, 1'b0, 1'b0, "R2");
    runQuery(8'h48, 8'h00, 16'd1, 1, 0, 1'b0, 1'b0, "R2");
    runQuery(8'h48, 8'h00, 16'd2, 1, 5, 1'b0, 1'b0, "R3");
    runQuery(8'h48, 8'h00, 16'd2, 1, 200, 1'b0, 1'b0, "R3");
  endtask

  task automatic testReads();
    runQuery(8'h48, 8'h00, 16'd2, 2, 1, 1'b0, 1'b0, "R4");
    runQuery(8'h48, 8'h00, 16'd2, 10, 3, 1'b1, 1'b0, "R4");
    runQuery(8'h48, 8'h00, 16'd2, 0, 0, 1'b0, 1'b0, "R7");
    runQuery(8'h48, 8'h00, 16'd2, 1, 4, 1'b1, 1'b0, "R6");
  endtask

  task automatic testLock();
    runQuery(8'h48, 8'h00, 16'd2, 1, 0, 1'b1, 1'b1, "R9");
    runQuery(8'h48, 8'h00, 16'd2, 8, 0, 1'b0, 1'b0, "R9");
    writeTbl(3'd6, 0, 64'd9);
    runQuery(8'h48, 8'h00, 16'd2, 8, 0, 1'b0, 1'b0, "R9");
  endtask

  task automatic testFull();
    loadRegion(5); loadRegion(6); loadRegion(7);
    writeTbl(3'd6, 0, 64'd8);
    mCount = 8;
    runQuery(8'h48, 8'h00, 16'd2, 8, 0, 1'b1, 1'b0, "R4");
    runQuery(8'h48, 8'h00, 16'd2, 255, 7, 1'b0, 1'b0, "R6");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    for (int r = 0; r < 5; r++) loadRegion(r);
    writeTbl(3'd6, 0, 64'd5);
    mCount = 5;
    testDecode();
    testReads();
    testLock();
    testFull();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(5 * 200000);
    failed++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule